// File: doc/BRIEF.md
# Prefetchable Window Forwarding Decoder

This block sits in a two-port bus bridge and decides, one memory transaction at a time, whether the bridge claims the transaction and passes it to the opposite side. Software sets up a prefetchable address window through a small register write port. The window has a base register, a limit register, a memory-space enable and a legacy video enable. The window is aligned to 1 MB. Its bottom is the base with the low 20 address bits at zero. Its top is the limit with the low 20 address bits at one, so the limit address is part of the window.

Transactions arrive on a valid/ready request stream that carries a 32-bit address and the side the transaction came from. One cycle after a request is accepted, a registered decision appears on a valid/ready result stream. The decision says forward or ignore and echoes the originating side.

The result stage holds one entry. A new request is accepted when that stage is empty or when the consumer takes the current result in the same cycle. While the consumer holds `dec_ready` low with a result pending, the result stays stable and `req_ready` is low.

Top module: `pwin_fwd_decoder`

## Requirements
- R1: `cfg_sel` selects a register: 0 is base, 1 is limit, 2 is control. Base and limit keep address bits 31:20 in data bits 15:4. Their data bits 3:0 read as zero and ignore writes. In the control register, bit 0 is memory-space enable and bit 1 is video enable. All three registers reset to zero, and `cfg_rdata` shows the register selected by `cfg_sel`.
- R2: An address is inside the window when its bits 31:20 are at least the base field and at most the limit field. Both ends are inclusive, so the window runs from base·2^20 to limit·2^20 + 0xFFFFF.
- R3: A request from the primary side (`req_side`=0) is forwarded when its address is inside the window, and ignored otherwise.
- R4: A request from the secondary side (`req_side`=1) is forwarded when its address is outside the window, and ignored when it is inside.
- R5: When video enable is set, a primary-side address from 0x000A0000 to 0x000BFFFF is forwarded, whatever the window holds.
- R6: When video enable is set, a secondary-side address from 0x000A0000 to 0x000BFFFF is never forwarded.
- R7: When memory-space enable is clear, nothing is forwarded on either side, including the video range.
- R8: When the limit field is below the base field, no window-based forwarding happens on either side. The video-range rules of R5 and R6 still apply.
- R9: An accepted request (`req_valid` and `req_ready` both high) produces `dec_valid` in the next cycle, carrying the decision on `dec_fwd` and the request side on `dec_side`.
- R10: `req_ready` equals `!dec_valid || dec_ready`. While `dec_valid` is high and `dec_ready` is low, `dec_fwd` and `dec_side` hold their values.
- R11: A register write in the same cycle as an accepted request affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 base, 1 limit, 2 control) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Contents of the selected register |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 32 | Transaction address |
| req_side | input | 1 | Originating side (0 primary, 1 secondary) |
| dec_valid | output | 1 | Decision valid |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_fwd | output | 1 | 1 forward to the other side, 0 ignore |
| dec_side | output | 1 | Side of the decided request |

## Verification
Each decision is due exactly one clock after its request is accepted. The bench drives inputs on the falling edge and reads `dec_valid`, `dec_fwd` and `dec_side` on the next falling edge. Register writes take effect at the rising edge after the strobe, so `cfg_rdata` is read half a cycle after that edge, and the same-cycle test expects the old settings. In stall tests the bench holds `dec_ready` low for several falling edges, checks that the result and `req_ready` stay put, and then releases `dec_ready`.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  localparam int ADDR_W    = 32;
  localparam int GRAN_BITS = 20;
  localparam int FIELD_W   = ADDR_W - GRAN_BITS;
  localparam int FIELD_LSB = 4;
  localparam int REG_W     = 16;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_CTRL  = 2'd2
  } cfg_sel_e;

  typedef enum logic {
    SIDE_PRI = 1'b0,
    SIDE_SEC = 1'b1
  } side_e;

  typedef struct packed {
    logic [FIELD_W-1:0] base;
    logic [FIELD_W-1:0] limit;
    logic               mem_en;
    logic               vid_en;
  } win_cfg_t;
endpackage

// File: rtl/pwin_cfg_regs.sv
module pwin_cfg_regs
  import pwin_pkg::*;
#(
  parameter int FW  = FIELD_W,
  parameter int LSB = FIELD_LSB,
  parameter int RW  = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] rdata,
  output logic [FW-1:0] base,
  output logic [FW-1:0] limit,
  output logic          mem_en,
  output logic          vid_en
);
  localparam int TOP = LSB + FW - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base   <= '0;
      limit  <= '0;
      mem_en <= 1'b0;
      vid_en <= 1'b0;
    end else if (we) begin
      case (sel)
        SEL_BASE:  base  <= wdata[TOP:LSB];
        SEL_LIMIT: limit <= wdata[TOP:LSB];
        SEL_CTRL: begin
          mem_en <= wdata[0];
          vid_en <= wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_BASE:  rdata[TOP:LSB] = base;
      SEL_LIMIT: rdata[TOP:LSB] = limit;
      SEL_CTRL:  rdata[1:0]     = {vid_en, mem_en};
      default:   rdata          = '0;
    endcase
  end

  assert_limit_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_LIMIT) |=> limit == $past(wdata[TOP:LSB]));
  assert_base_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_BASE) |=> base == $past(wdata[TOP:LSB]));
endmodule

// File: rtl/pwin_range_cmp.sv
module pwin_range_cmp
  import pwin_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int GB = GRAN_BITS,
  parameter logic [AW-1:0] VID_LO = 32'h000A_0000,
  parameter logic [AW-1:0] VID_HI = 32'h000B_FFFF
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-GB-1:0] base,
  input  logic [AW-GB-1:0] limit,
  output logic             win_ok,
  output logic             win_hit,
  output logic             vid_hit
);
  logic [AW-GB-1:0] page;
  assign page    = addr[AW-1:GB];
  assign win_ok  = (limit >= base);
  assign win_hit = win_ok && (page >= base) && (page <= limit);
  assign vid_hit = (addr >= VID_LO) && (addr <= VID_HI);
endmodule

// File: rtl/pwin_fwd_decoder.sv
module pwin_fwd_decoder
  import pwin_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_side,
  output logic          dec_valid,
  input  logic          dec_ready,
  output logic          dec_fwd,
  output logic          dec_side
);
  localparam int FW = AW - GRAN_BITS;

  win_cfg_t cfg;
  logic win_ok, win_hit, vid_hit, fwd_next, req_fire;

  pwin_cfg_regs #(.FW(FW), .LSB(FIELD_LSB), .RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .base(cfg.base), .limit(cfg.limit),
    .mem_en(cfg.mem_en), .vid_en(cfg.vid_en)
  );

  pwin_range_cmp #(.AW(AW), .GB(GRAN_BITS)) u_cmp (
    .addr(req_addr), .base(cfg.base), .limit(cfg.limit),
    .win_ok(win_ok), .win_hit(win_hit), .vid_hit(vid_hit)
  );

  always_comb begin
    if (!cfg.mem_en)                 fwd_next = 1'b0;
    else if (cfg.vid_en && vid_hit)  fwd_next = (req_side == SIDE_PRI);
    else if (!win_ok)                fwd_next = 1'b0;
    else if (req_side == SIDE_PRI)   fwd_next = win_hit;
    else                             fwd_next = !win_hit;
  end

  assign req_ready = !dec_valid || dec_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_fwd   <= 1'b0;
      dec_side  <= 1'b0;
    end else if (req_fire) begin
      dec_valid <= 1'b1;
      dec_fwd   <= fwd_next;
      dec_side  <= req_side;
    end else if (dec_ready) begin
      dec_valid <= 1'b0;
    end
  end

  assert_result_due_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> dec_valid && dec_side == $past(req_side));
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> dec_valid && $stable(dec_fwd) && $stable(dec_side));
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !cfg.mem_en) |=> !dec_fwd);
  assert_video_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_side && cfg.vid_en && vid_hit) |=> !dec_fwd);
endmodule

// File: tb/tb_pwin_fwd_decoder.sv
module tb_pwin_fwd_decoder;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;
  logic req_valid = 0, req_ready, req_side = 0;
  logic [31:0] req_addr = 0;
  logic dec_valid, dec_ready = 1, dec_fwd, dec_side;
  int checks = 0, fails = 0;
  logic [11:0] m_base = 0, m_lim = 0; logic m_men = 0, m_ven = 0;

  always #2.5 clk = ~clk;

  pwin_fwd_decoder dut (.*);

  function automatic logic model(input logic [31:0] a, input logic s);
    logic ok, hit, vid;
    ok  = m_lim >= m_base;
    hit = ok && a[31:20] >= m_base && a[31:20] <= m_lim;
    vid = a >= 32'h000A0000 && a <= 32'h000BFFFF;
    if (!m_men) return 0;
    if (m_ven && vid) return !s;
    if (!ok) return 0;
    return s ? !hit : hit;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    if (s == 0) m_base = d[15:4];
    else if (s == 1) m_lim = d[15:4];
    else begin m_men = d[0]; m_ven = d[1]; end
  endtask

  task automatic setwin(input logic [11:0] b, input logic [11:0] l, input logic men, input logic ven);
    wr(0, {b, 4'h0}); wr(1, {l, 4'h0}); wr(2, {14'h0, ven, men});
  endtask

  task automatic xact(input string r, input logic [31:0] a, input logic s);
    logic e;
    e = model(a, s);
    @(negedge clk); req_valid = 1; req_addr = a; req_side = s;
    @(negedge clk); req_valid = 0;
    chk({r, " valid"}, dec_valid, 1);
    chk({r, " fwd"}, dec_fwd, e);
    chk({r, " side"}, dec_side, s);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    for (int s = 0; s < 3; s++) begin
      cfg_sel = s[1:0]; #1; chk("R1 reset reg", cfg_rdata, 0);
    end
    chk("R9 reset valid", dec_valid, 0);
    chk("R10 reset ready", req_ready, 1);
    // R1 reserved bits ignored
    wr(1, 16'hABCF); cfg_sel = 1; #1; chk("R1 limit rsv", cfg_rdata, 16'hABC0);
    wr(0, 16'h123F); cfg_sel = 0; #1; chk("R1 base rsv", cfg_rdata, 16'h1230);
    wr(2, 16'hFFFF); cfg_sel = 2; #1; chk("R1 ctrl", cfg_rdata, 16'h0003);
    // R7 disabled
    setwin(12'h100, 12'h1FF, 0, 1);
    xact("R7 pri in", 32'h1000_0000, 0);
    xact("R7 sec out", 32'h0000_0000, 1);
    xact("R7 vid", 32'h000A_0000, 0);
    // R2/R3/R4 edges
    setwin(12'h100, 12'h10F, 1, 0);
    xact("R2 base edge", 32'h1000_0000, 0);
    xact("R2 below", 32'h0FFF_FFFF, 0);
    xact("R2 limit top", 32'h10FF_FFFF, 0);
    xact("R2 above", 32'h1100_0000, 0);
    xact("R3 pri in", 32'h1080_1234, 0);
    xact("R4 sec in", 32'h1080_1234, 1);
    xact("R4 sec out", 32'h2000_0000, 1);
    // R5/R6 video
    setwin(12'h100, 12'h10F, 1, 1);
    xact("R5 vid lo", 32'h000A_0000, 0);
    xact("R5 vid hi", 32'h000B_FFFF, 0);
    xact("R5 vid past", 32'h000C_0000, 0);
    xact("R6 vid sec", 32'h000A_8000, 1);
    xact("R6 sec below vid", 32'h0009_FFFF, 1);
    // R6 video range inside window
    setwin(12'h000, 12'h001, 1, 1);
    xact("R6 vid in window", 32'h000B_0000, 1);
    xact("R5 vid in window", 32'h000B_0000, 0);
    // R8 inverted
    setwin(12'h200, 12'h100, 1, 1);
    xact("R8 pri", 32'h1800_0000, 0);
    xact("R8 sec", 32'h3000_0000, 1);
    xact("R8 vid pri", 32'h000A_0000, 0);
    // R11 same-cycle write
    setwin(12'h100, 12'h1FF, 1, 0);
    @(negedge clk); req_valid = 1; req_addr = 32'h1500_0000; req_side = 0;
    cfg_we = 1; cfg_sel = 2; cfg_wdata = 16'h0000;
    @(negedge clk); req_valid = 0; cfg_we = 0;
    chk("R11 old cfg used", dec_fwd, 1);
    m_men = 0;
    xact("R11 new cfg", 32'h1500_0000, 0);
    // R10 stall
    setwin(12'h100, 12'h1FF, 1, 0);
    dec_ready = 0;
    @(negedge clk); req_valid = 1; req_addr = 32'h1500_0000; req_side = 1;
    @(negedge clk); req_addr = 32'h0000_0000;
    chk("R10 valid", dec_valid, 1); chk("R10 ready low", req_ready, 0);
    repeat (3) @(negedge clk);
    chk("R10 held fwd", dec_fwd, 0); chk("R10 held side", dec_side, 1);
    dec_ready = 1; #1; chk("R10 ready follows", req_ready, 1);
    @(negedge clk); req_valid = 0;
    chk("R10 next accepted", dec_fwd, 1);
    @(negedge clk);
    chk("R9 pulse ends", dec_valid, 0);
    // random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a; logic [11:0] b, l;
      if (i % 40 == 0) begin
        b = $urandom; l = ($urandom % 4 == 0) ? b - 12'($urandom % 8) : b + 12'($urandom % 64);
        setwin(b, l, ($urandom % 8) != 0, $urandom);
      end
      case ($urandom % 4)
        0: a = {m_base, 20'h0} - 32'($urandom % 2);
        1: a = {m_lim, 20'hFFFFF} + 32'($urandom % 2);
        2: a = 32'h000A0000 + 32'($urandom % 32'h20001) - 1;
        default: a = $urandom;
      endcase
      xact("R3 R4 R5 R6 R8 random", a, $urandom);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule